// File: doc/BRIEF.md
# Peripheral Target Agent Register Block

This block is the small register set that guards one peripheral on an on-chip peripheral interconnect. A 32-bit register port reaches three words: a fixed identifier, a control word whose writable bits are limited by a mask, and a status word holding a sticky request-timeout flag. The timeout counter is outside the block and raises `tmo_evt` for one cycle when a request to the peripheral has timed out. Software clears the flag by writing the control word with its reset-command bit set. That bit is never stored. It produces a one-cycle reset pulse toward the peripheral.

Every request on the port gets one registered response in the next cycle. Only full-word accesses are legal. A narrower access, an access to an offset with no register, or a write to a read-only word completes as usual but raises the error flag, returns zero data and changes no state. The stored control word drives the peripheral's control pins directly.

Top module: `tagent_regs`

## Requirements
- R1: After reset, the control word is 0x00000200, the timeout flag is 0, `rsp_valid` is 0 and `periph_rst` is 0.
- R2: A word read at offset 0x00 returns the identifier 0x54414754, which is the ASCII characters "TAGT" with the first character in bits 31:24, and has no error.
- R3: A legal word write at offset 0x20 stores `wdata & 0x01000700`. A read at 0x20 returns the stored value, and all other bits read as zero.
- R4: A cycle with `tmo_evt` high sets the timeout flag, which is bit 0 of the word at offset 0x28 (all other bits zero). The flag stays set until it is cleared by R5.
- R5: A legal write at 0x20 with data bit 0 set clears the timeout flag and drives `periph_rst` high for exactly the response cycle. Bit 0 is not stored and reads back as 0.
- R6: If `tmo_evt` and a clearing write occur in the same cycle, the flag ends up set.
- R7: `req_size` encodes 0 = byte, 1 = halfword, 2 = word (3 is also non-word). Any non-word access sets `rsp_err`, returns zero data and changes no register.
- R8: An access at any offset other than 0x00, 0x20 or 0x28 sets `rsp_err`, returns zero data and changes no register.
- R9: A word write to 0x00 or 0x28 sets `rsp_err` and changes neither the identifier nor the timeout flag.
- R10: `rsp_valid` is high exactly in the cycle after each cycle with `req_valid` high. `rsp_err` is high only together with `rsp_valid`.
- R11: `periph_ctl` always equals the stored control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset inside the agent |
| req_size | input | 2 | Access width code (2 = word) |
| req_wdata | input | 32 | Write data |
| tmo_evt | input | 1 | Request-timeout event pulse |
| rsp_valid | output | 1 | Response cycle |
| rsp_rdata | output | 32 | Read data, zero on error or write |
| rsp_err | output | 1 | Access error flag |
| periph_ctl | output | 32 | Stored control word to the peripheral |
| periph_rst | output | 1 | One-cycle reset command pulse |

## Verification
The assertions check the parts of the protocol that hold every cycle. They cover the one-cycle response timing, the rule that an error appears only with a response, zero data on errors, the immediate error on non-word sizes, a control word that stays still without a write, and a timeout flag that sets and stays set. Other behaviour is visible only through access sequences in the bench. That includes the exact masked value read back, the identifier contents, the set-wins race between a timeout and a clearing write, and the fact that rejected writes to read-only or unknown offsets leave the registers unchanged.

// File: rtl/ic_ta_pkg.sv
package ic_ta_pkg;
    localparam int unsigned DW = 32;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_IDENT,
        SEL_CTRL,
        SEL_STAT
    } reg_sel_e;

    typedef enum logic [1:0] {
        KIND_OK,
        KIND_BADW,
        KIND_BADREG,
        KIND_ROWR
    } acc_kind_e;

    typedef struct packed {
        logic [DW-1:0] ctrl;
        logic          stat_tmo;
        logic          rsp_valid;
        logic          rsp_err;
        logic [DW-1:0] rsp_rdata;
        logic          rst_cmd;
    } ta_state_t;
endpackage

// File: rtl/ic_ta_decode.sv
module ic_ta_decode
    import ic_ta_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned IDENT_OFS = 'h00,
    parameter int unsigned CTRL_OFS  = 'h20,
    parameter int unsigned STAT_OFS  = 'h28
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              write,
    input  logic [1:0]        size,
    output reg_sel_e          sel,
    output acc_kind_e         kind
);
    localparam logic [ADDR_W-1:0] IDENT_A = ADDR_W'(IDENT_OFS);
    localparam logic [ADDR_W-1:0] CTRL_A  = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] STAT_A  = ADDR_W'(STAT_OFS);

    always_comb begin
        if (addr == IDENT_A)      sel = SEL_IDENT;
        else if (addr == CTRL_A)  sel = SEL_CTRL;
        else if (addr == STAT_A)  sel = SEL_STAT;
        else                      sel = SEL_NONE;
    end

    // Width is checked first, then the offset, then write permission.
    always_comb begin
        if (acc_size_e'(size) != SZ_WORD)                  kind = KIND_BADW;
        else if (sel == SEL_NONE)                          kind = KIND_BADREG;
        else if (write && (sel == SEL_IDENT || sel == SEL_STAT)) kind = KIND_ROWR;
        else                                               kind = KIND_OK;
    end
endmodule

// File: rtl/ic_ta_regfile.sv
module ic_ta_regfile
    import ic_ta_pkg::*;
#(
    parameter logic [DW-1:0] IDENT_WORD = 32'h5441_4754,
    parameter logic [DW-1:0] CTRL_MASK  = 32'h0100_0700,
    parameter logic [DW-1:0] CTRL_INIT  = 32'h0000_0200
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [1:0]    req_size,
    input  logic [DW-1:0] req_wdata,
    input  reg_sel_e      sel,
    input  acc_kind_e     kind,
    input  logic          tmo_evt,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic          rsp_err,
    output logic [DW-1:0] ctrl_word,
    output logic          rst_cmd
);
    localparam ta_state_t RESET_STATE = '{
        ctrl:      CTRL_INIT & CTRL_MASK,
        stat_tmo:  1'b0,
        rsp_valid: 1'b0,
        rsp_err:   1'b0,
        rsp_rdata: '0,
        rst_cmd:   1'b0
    };

    ta_state_t st_d, st_q;
    logic      clr_req;

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = req_valid;
        st_d.rsp_err   = 1'b0;
        st_d.rsp_rdata = '0;
        st_d.rst_cmd   = 1'b0;
        clr_req        = 1'b0;

        if (req_valid) begin
            st_d.rsp_err = (kind != KIND_OK);
            if (kind == KIND_OK) begin
                if (req_write) begin
                    if (sel == SEL_CTRL) begin
                        st_d.ctrl    = req_wdata & CTRL_MASK;
                        clr_req      = req_wdata[0];
                        st_d.rst_cmd = req_wdata[0];
                    end
                end else begin
                    unique case (sel)
                        SEL_IDENT: st_d.rsp_rdata = IDENT_WORD;
                        SEL_CTRL:  st_d.rsp_rdata = st_q.ctrl;
                        SEL_STAT:  st_d.rsp_rdata = {{(DW-1){1'b0}}, st_q.stat_tmo};
                        default:   st_d.rsp_rdata = '0;
                    endcase
                end
            end
        end

        // A new timeout event takes precedence over a clear in the same cycle.
        if (tmo_evt)      st_d.stat_tmo = 1'b1;
        else if (clr_req) st_d.stat_tmo = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RESET_STATE;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_rdata = st_q.rsp_rdata;
    assign rsp_err   = st_q.rsp_err;
    assign ctrl_word = st_q.ctrl;
    assign rst_cmd   = st_q.rst_cmd;

    // R10
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R10
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R10
    err_with_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_valid);
    // R7
    badwidth_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size != 2'd2) |=> rsp_err);
    // R8
    err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_rdata == '0));
    // R3
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write) |=> $stable(ctrl_word));
    // R4
    tmo_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_evt |=> st_q.stat_tmo);
    // R4
    tmo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stat_tmo && !(req_valid && req_write && sel == SEL_CTRL && req_wdata[0]))
        |=> st_q.stat_tmo);
endmodule

// File: rtl/tagent_regs.sv
module tagent_regs
    import ic_ta_pkg::*;
#(
    parameter int unsigned   ADDR_W     = 8,
    parameter logic [31:0]   IDENT_WORD = 32'h5441_4754,
    parameter logic [31:0]   CTRL_MASK  = 32'h0100_0700,
    parameter logic [31:0]   CTRL_INIT  = 32'h0000_0200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_wdata,
    input  logic              tmo_evt,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_err,
    output logic [31:0]       periph_ctl,
    output logic              periph_rst
);
    reg_sel_e  acc_sel;
    acc_kind_e acc_kind;

    ic_ta_decode #(
        .ADDR_W(ADDR_W)
    ) u_decode (
        .addr  (req_addr),
        .write (req_write),
        .size  (req_size),
        .sel   (acc_sel),
        .kind  (acc_kind)
    );

    ic_ta_regfile #(
        .IDENT_WORD(IDENT_WORD),
        .CTRL_MASK (CTRL_MASK),
        .CTRL_INIT (CTRL_INIT)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_size  (req_size),
        .req_wdata (req_wdata),
        .sel       (acc_sel),
        .kind      (acc_kind),
        .tmo_evt   (tmo_evt),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .rsp_err   (rsp_err),
        .ctrl_word (periph_ctl),
        .rst_cmd   (periph_rst)
    );
endmodule

// File: tb/tagent_regs_test.sv
`timescale 1ns/1ps
module tagent_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [1:0]  req_size = 2'd2;
    logic [31:0] req_wdata = '0;
    logic        tmo_evt = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_err;
    logic [31:0] periph_ctl;
    logic        periph_rst;

    int checks = 0;
    int failures = 0;
    logic [31:0] got_data;
    logic        got_err;
    logic        got_rst;

    always #2.5 clk = ~clk;

    tagent_regs uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .tmo_evt(tmo_evt), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_err(rsp_err), .periph_ctl(periph_ctl), .periph_rst(periph_rst)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // One access; tmo drives the timeout input in the same cycle.
    task automatic access(input logic wr, input logic [7:0] a, input logic [1:0] sz,
                          input logic [31:0] wd, input logic tmo);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz;
        req_wdata = wd; tmo_evt = tmo;
        @(negedge clk);
        req_valid = 1'b0; tmo_evt = 1'b0;
        chk("R10 rsp_valid", {31'b0, rsp_valid}, 32'd1);
        got_data = rsp_rdata; got_err = rsp_err; got_rst = periph_rst;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk("R10 idle no rsp", {30'b0, rsp_valid, rsp_err}, 32'd0);
        end
    endtask

    task automatic pulse_tmo();
        @(negedge clk); tmo_evt = 1'b1;
        @(negedge clk); tmo_evt = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 ctrl reset", periph_ctl, 32'h200);
        chk("R1 rsp_valid reset", {31'b0, rsp_valid}, 32'd0);
        chk("R1 periph_rst reset", {31'b0, periph_rst}, 32'd0);
        access(1'b0, 8'h28, 2'd2, '0, 1'b0);
        chk("R1 stat reset", got_data, 32'h0);
        access(1'b0, 8'h20, 2'd2, '0, 1'b0);
        chk("R1 ctrl read reset", got_data, 32'h200);
    endtask

    task automatic t_ident();
        access(1'b0, 8'h00, 2'd2, '0, 1'b0);
        chk("R2 ident", got_data, 32'h5441_4754);
        chk("R2 no err", {31'b0, got_err}, 32'd0);
    endtask

    task automatic t_ctrl();
        access(1'b1, 8'h20, 2'd2, 32'hFFFF_FFFE, 1'b0);
        chk("R3 write ok", {31'b0, got_err}, 32'd0);
        access(1'b0, 8'h20, 2'd2, '0, 1'b0);
        chk("R3 masked all", got_data, 32'h0100_0700);
        chk("R11 ctl pins", periph_ctl, 32'h0100_0700);
        access(1'b1, 8'h20, 2'd2, 32'h00FF_0100, 1'b0);
        access(1'b0, 8'h20, 2'd2, '0, 1'b0);
        chk("R3 masked partial", got_data, 32'h0000_0100);
        chk("R11 ctl pins 2", periph_ctl, 32'h0000_0100);
    endtask

    task automatic t_tmo_clear();
        pulse_tmo();
        idle(3);
        access(1'b0, 8'h28, 2'd2, '0, 1'b0);
        chk("R4 flag set sticky", got_data, 32'h1);
        access(1'b1, 8'h20, 2'd2, 32'h0000_0201, 1'b0);
        chk("R5 periph_rst pulse", {31'b0, got_rst}, 32'd1);
        @(negedge clk);
        chk("R5 pulse one cycle", {31'b0, periph_rst}, 32'd0);
        access(1'b0, 8'h28, 2'd2, '0, 1'b0);
        chk("R5 flag cleared", got_data, 32'h0);
        access(1'b0, 8'h20, 2'd2, '0, 1'b0);
        chk("R5 bit0 not stored", got_data, 32'h200);
    endtask

    task automatic t_race();
        access(1'b1, 8'h20, 2'd2, 32'h0000_0001, 1'b1);
        access(1'b0, 8'h28, 2'd2, '0, 1'b0);
        chk("R6 set wins", got_data, 32'h1);
        access(1'b1, 8'h20, 2'd2, 32'h0000_0201, 1'b0);
        access(1'b0, 8'h28, 2'd2, '0, 1'b0);
        chk("R6 later clear", got_data, 32'h0);
    endtask

    task automatic t_width();
        for (int s = 0; s < 4; s++) begin
            if (s == 2) continue;
            access(1'b0, 8'h00, 2'(s), '0, 1'b0);
            chk("R7 narrow read err", {31'b0, got_err}, 32'd1);
            chk("R7 narrow read zero", got_data, 32'h0);
        end
        access(1'b1, 8'h20, 2'd1, 32'h0100_0000, 1'b0);
        chk("R7 narrow write err", {31'b0, got_err}, 32'd1);
        pulse_tmo();
        access(1'b1, 8'h20, 2'd0, 32'h0000_0001, 1'b0);
        chk("R7 narrow no pulse", {31'b0, got_rst}, 32'd0);
        access(1'b0, 8'h20, 2'd2, '0, 1'b0);
        chk("R7 ctrl unchanged", got_data, 32'h200);
        access(1'b0, 8'h28, 2'd2, '0, 1'b0);
        chk("R7 flag unchanged", got_data, 32'h1);
    endtask

    task automatic t_badreg();
        access(1'b0, 8'h04, 2'd2, '0, 1'b0);
        chk("R8 read err", {31'b0, got_err}, 32'd1);
        chk("R8 read zero", got_data, 32'h0);
        access(1'b0, 8'h21, 2'd2, '0, 1'b0);
        chk("R8 misaligned err", {31'b0, got_err}, 32'd1);
        access(1'b1, 8'h24, 2'd2, 32'h0100_0001, 1'b0);
        chk("R8 write err", {31'b0, got_err}, 32'd1);
        access(1'b0, 8'h20, 2'd2, '0, 1'b0);
        chk("R8 ctrl unchanged", got_data, 32'h200);
        access(1'b0, 8'h28, 2'd2, '0, 1'b0);
        chk("R8 flag unchanged", got_data, 32'h1);
    endtask

    task automatic t_readonly();
        access(1'b1, 8'h00, 2'd2, 32'h1234_5678, 1'b0);
        chk("R9 ident write err", {31'b0, got_err}, 32'd1);
        access(1'b0, 8'h00, 2'd2, '0, 1'b0);
        chk("R9 ident unchanged", got_data, 32'h5441_4754);
        access(1'b1, 8'h28, 2'd2, 32'h0000_0000, 1'b0);
        chk("R9 stat write err", {31'b0, got_err}, 32'd1);
        access(1'b0, 8'h28, 2'd2, '0, 1'b0);
        chk("R9 flag unchanged", got_data, 32'h1);
        chk("R9 ctrl untouched", periph_ctl, 32'h200);
    endtask

    initial begin
        #(5.0 * 200000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ident();
        t_ctrl();
        access(1'b1, 8'h20, 2'd2, 32'h0000_0200, 1'b0);
        t_tmo_clear();
        t_race();
        t_width();
        t_badreg();
        t_readonly();
        idle(2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule